// File: doc/BRIEF.md
# Change-of-State Input Interrupt Controller

This block watches a 16-channel window of a 32-bit digital input port (bits 19 down to 4) and raises an interrupt when those inputs change in a configured way. Each channel can be picked by two masks. One selects a rising edge or a high level. The other selects a falling edge or a low level. In edge mode, any selected channel that shows its chosen edge fires the interrupt. In level mode, the interrupt fires only when every selected channel sits at its chosen level at the same time. After a level-mode event, the logic stays locked out until a selected input changes level.

Software loads the mode and the two masks through a small register write port, then raises a separate enable. The enable keeps change-of-state detection running until it is dropped. Each event is stored in a 32-bit event word, which holds sticky flags for the change-of-state event, for an external timer event and for three external counter events, plus a snapshot of the 16 watched inputs. The interrupt output stays high while any flag is set. Flags are cleared by writing ones to the status address.

Top module: `chg_state_irq`

## Requirements
- R1: After reset, `irq` is 0 and `evt_word` is all zeros.
- R2: Only `din[19:4]` take part in detection, with channel k on `din[4+k]`. Toggling `din[3:0]` or `din[31:20]` never causes an event, even with all mask bits set.
- R3: In edge mode (address 0, value 1), a rising edge on a channel whose bit is set in the high mask (address 1, bit k) sets `evt_word[31]` and `irq` on the third rising clock edge after the input changes, and not before.
- R4: In edge mode, a falling edge on a channel whose bit is set in the low mask (address 2, bit k) raises the same event.
- R5: Edges on unselected channels, and edges of the opposite polarity to the one a channel is selected for, cause no event. Mode values 0 and 3 disable detection.
- R6: In level mode (address 0, value 2), an event fires when every channel selected in the high mask is 1 and every channel selected in the low mask is 0. A partial match causes no event.
- R7: After a level-mode event, no further level-mode event is raised while the condition simply persists, or while only unselected inputs change. A level change on a selected channel re-arms the logic, and the next full match fires again.
- R8: While `irq_en` is 0, no change-of-state event is raised.
- R9: The event word is laid out as follows. Bit 31 is the change-of-state flag. Bit 30 is set one cycle after a `tmr_pulse`. Bits 29, 28 and 27 are set one cycle after pulses on `cnt_pulse[2]`, `cnt_pulse[1]` and `cnt_pulse[0]`. Bits 19:4 hold the synchronized inputs captured on the latest event. Bits 26:20 and 3:0 are always 0.
- R10: A write to address 3 clears each event flag whose bit position in the write data is 1 and leaves the other flags unchanged. `irq` falls once no flag remains set.
- R11: An event that arrives in the same cycle as a clear of its flag wins, so the flag stays set.
- R12: Writing address 0, 1 or 2 while enabled releases a level-mode lockout. If the level condition still holds, an event fires on the clock edge after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| din | input | 32 | Raw digital input port |
| irq_en | input | 1 | Change-of-state detection enable |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address: 0 mode, 1 high mask, 2 low mask, 3 status clear |
| cfg_wdata | input | 32 | Register write data |
| tmr_pulse | input | 1 | Single-cycle timer event |
| cnt_pulse | input | 3 | Single-cycle counter events |
| irq | output | 1 | Interrupt request, high while any flag is set |
| evt_word | output | 32 | Event flags and input snapshot |

## Verification
Two functions can land in the same cycle: a status write that clears a flag, and a new event that sets that same flag. The bench provokes this twice. First it drives a timer pulse in the same cycle as a write clearing bit 30. Then it times an input edge so that its change-of-state capture coincides with a write clearing bit 31. In both cases the flag must read 1 afterwards. A second case checks that a mask write releases the level lockout while the write itself suppresses detection, so the event appears exactly one edge later.

// File: rtl/csi_pkg.sv
`timescale 1ns/1ps
package csi_pkg;
   typedef enum logic [1:0] {
      CSI_OFF  = 2'd0,
      CSI_EDGE = 2'd1,
      CSI_LVL  = 2'd2,
      CSI_OFFX = 2'd3
   } csi_mode_e;

   localparam int EVW      = 32;
   localparam logic [1:0] A_MODE = 2'd0;
   localparam logic [1:0] A_HI   = 2'd1;
   localparam logic [1:0] A_LO   = 2'd2;
   localparam logic [1:0] A_STAT = 2'd3;
endpackage

// File: rtl/csi_sync.sv
`timescale 1ns/1ps
module csi_sync #(
   parameter int W      = 16,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q,
   output logic [W-1:0] q_prev
);
   logic [STAGES-1:0][W-1:0] st;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= '0;
         q_prev <= '0;
      end else begin
         st[0] <= d;
         for (int s = 1; s < STAGES; s++) st[s] <= st[s-1];
         q_prev <= st[STAGES-1];
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/csi_cfg.sv
`timescale 1ns/1ps
module csi_cfg
   import csi_pkg::*;
#(
   parameter int CH_N = 16,
   parameter int NF   = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [1:0]      addr,
   input  logic [EVW-1:0]  wdata,
   output csi_mode_e       mode,
   output logic [CH_N-1:0] mask_hi,
   output logic [CH_N-1:0] mask_lo,
   output logic            cfg_chg,
   output logic [NF-1:0]   clr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode    <= CSI_OFF;
         mask_hi <= '0;
         mask_lo <= '0;
      end else if (we) begin
         case (addr)
            A_MODE:  mode    <= csi_mode_e'(wdata[1:0]);
            A_HI:    mask_hi <= wdata[CH_N-1:0];
            A_LO:    mask_lo <= wdata[CH_N-1:0];
            default: ;
         endcase
      end
   end

   assign cfg_chg = we && (addr != A_STAT);
   assign clr     = (we && addr == A_STAT) ? wdata[EVW-1 -: NF] : '0;
endmodule

// File: rtl/csi_detect.sv
`timescale 1ns/1ps
module csi_detect
   import csi_pkg::*;
#(
   parameter int CH_N = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  csi_mode_e       mode,
   input  logic [CH_N-1:0] mask_hi,
   input  logic [CH_N-1:0] mask_lo,
   input  logic            cfg_chg,
   input  logic [CH_N-1:0] cur,
   input  logic [CH_N-1:0] prev,
   output logic            cos_hit
);
   logic [CH_N-1:0] edge_ok;
   logic [CH_N-1:0] lvl_ok;
   logic [CH_N-1:0] sel;
   logic            armed;
   logic            edge_hit;
   logic            lvl_hit;
   logic            sel_moved;

   for (genvar k = 0; k < CH_N; k++) begin : g_ch
      assign edge_ok[k] = (mask_hi[k] &  cur[k] & ~prev[k]) |
                          (mask_lo[k] & ~cur[k] &  prev[k]);
      assign lvl_ok[k]  = (~mask_hi[k] | cur[k]) & (~mask_lo[k] | ~cur[k]);
      assign sel[k]     = mask_hi[k] | mask_lo[k];
   end

   assign sel_moved = |((cur ^ prev) & sel);
   assign edge_hit  = en && !cfg_chg && (mode == CSI_EDGE) && (|edge_ok);
   assign lvl_hit   = en && !cfg_chg && (mode == CSI_LVL) && armed &&
                      (|sel) && (&lvl_ok);
   assign cos_hit   = edge_hit || lvl_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          armed <= 1'b1;
      else if (cfg_chg)    armed <= 1'b1;
      else if (lvl_hit)    armed <= 1'b0;
      else if (sel_moved)  armed <= 1'b1;
   end
endmodule

// File: rtl/csi_evt.sv
`timescale 1ns/1ps
module csi_evt
   import csi_pkg::*;
#(
   parameter int CH_N  = 16,
   parameter int CH_LO = 4,
   parameter int N_CNT = 3,
   localparam int NF   = N_CNT + 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cos_hit,
   input  logic            tmr_p,
   input  logic [N_CNT-1:0] cnt_p,
   input  logic [NF-1:0]   clr,
   input  logic [CH_N-1:0] cur,
   output logic [EVW-1:0]  word,
   output logic            irq
);
   logic [NF-1:0]   flags;
   logic [NF-1:0]   set;
   logic [CH_N-1:0] snap;

   assign set = {cos_hit, tmr_p, cnt_p};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags <= '0;
         snap  <= '0;
      end else begin
         flags <= (flags & ~clr) | set;
         if (|set) snap <= cur;
      end
   end

   always_comb begin
      word                 = '0;
      word[EVW-1 -: NF]    = flags;
      word[CH_LO +: CH_N]  = snap;
   end

   assign irq = |flags;
endmodule

// File: rtl/chg_state_irq.sv
`timescale 1ns/1ps
module chg_state_irq
   import csi_pkg::*;
#(
   parameter int DIN_W       = 32,
   parameter int CH_LO       = 4,
   parameter int CH_N        = 16,
   parameter int SYNC_STAGES = 2,
   parameter int N_CNT       = 3,
   localparam int NF         = N_CNT + 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIN_W-1:0] din,
   input  logic             irq_en,
   input  logic             cfg_we,
   input  logic [1:0]       cfg_addr,
   input  logic [EVW-1:0]   cfg_wdata,
   input  logic             tmr_pulse,
   input  logic [N_CNT-1:0] cnt_pulse,
   output logic             irq,
   output logic [EVW-1:0]   evt_word
);
   if (CH_LO + CH_N > DIN_W) begin : g_bad_win
      $error("channel window exceeds input port");
   end
   if (CH_LO + CH_N > EVW - NF) begin : g_bad_word
      $error("snapshot overlaps event flags");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("at least two synchronizer stages required");
   end

   csi_mode_e       mode;
   logic [CH_N-1:0] mask_hi, mask_lo, cur, prev;
   logic            cfg_chg, cos_hit;
   logic [NF-1:0]   clr;
   logic            unused_din;

   assign unused_din = ^din;

   csi_sync #(.W(CH_N), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(din[CH_LO +: CH_N]), .q(cur), .q_prev(prev)
   );

   csi_cfg #(.CH_N(CH_N), .NF(NF)) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
      .mode(mode), .mask_hi(mask_hi), .mask_lo(mask_lo), .cfg_chg(cfg_chg), .clr(clr)
   );

   csi_detect #(.CH_N(CH_N)) u_det (
      .clk(clk), .rst_n(rst_n), .en(irq_en), .mode(mode), .mask_hi(mask_hi),
      .mask_lo(mask_lo), .cfg_chg(cfg_chg), .cur(cur), .prev(prev), .cos_hit(cos_hit)
   );

   csi_evt #(.CH_N(CH_N), .CH_LO(CH_LO), .N_CNT(N_CNT)) u_evt (
      .clk(clk), .rst_n(rst_n), .cos_hit(cos_hit), .tmr_p(tmr_pulse),
      .cnt_p(cnt_pulse), .clr(clr), .cur(cur), .word(evt_word), .irq(irq)
   );
endmodule

// File: rtl/chg_state_irq_chk.sv
`timescale 1ns/1ps
module chg_state_irq_chk
   import csi_pkg::*;
#(
   parameter int N_CNT = 3,
   parameter int CH_LO = 4,
   parameter int CH_N  = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             irq_en,
   input logic             cfg_we,
   input logic [1:0]       cfg_addr,
   input logic [EVW-1:0]   cfg_wdata,
   input logic             tmr_pulse,
   input logic [N_CNT-1:0] cnt_pulse,
   input logic             cos_hit,
   input logic [EVW-1:0]   evt_word
);
   localparam int TMR_POS = EVW - 2;
   localparam int CNT_POS = EVW - 2 - N_CNT;

   AST_TMR_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_pulse |=> evt_word[TMR_POS]); // R9

   AST_CNT0_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_pulse[0] |=> evt_word[CNT_POS]); // R9

   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_word[CNT_POS-1:CH_LO+CH_N] == '0) && (evt_word[CH_LO-1:0] == '0)); // R9

   AST_SNAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !(cos_hit || tmr_pulse || (|cnt_pulse)) |=> $stable(evt_word[CH_LO +: CH_N])); // R9

   AST_COS_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(evt_word[EVW-1]) |-> $past(irq_en)); // R8

   AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr == A_STAT && cfg_wdata[TMR_POS] && !tmr_pulse)
      |=> !evt_word[TMR_POS]); // R10
endmodule

bind chg_state_irq chg_state_irq_chk #(.N_CNT(N_CNT), .CH_LO(CH_LO), .CH_N(CH_N)) u_chk (
   .clk(clk), .rst_n(rst_n), .irq_en(irq_en), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
   .cfg_wdata(cfg_wdata), .tmr_pulse(tmr_pulse), .cnt_pulse(cnt_pulse),
   .cos_hit(cos_hit), .evt_word(evt_word)
);

// File: tb/test_chg_state_irq.sv
`timescale 1ns/1ps
module test_chg_state_irq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] din = '0;
   logic        irq_en = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic        tmr_pulse = 1'b0;
   logic [2:0]  cnt_pulse = '0;
   logic        irq;
   logic [31:0] evt_word;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   chg_state_irq i_chg_state_irq (
      .clk(clk), .rst_n(rst_n), .din(din), .irq_en(irq_en), .cfg_we(cfg_we),
      .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .tmr_pulse(tmr_pulse),
      .cnt_pulse(cnt_pulse), .irq(irq), .evt_word(evt_word)
   );

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      tick(1);
      cfg_we = 1'b0; cfg_wdata = '0;
   endtask

   task automatic clear_all();
      wr(2'd3, 32'hF800_0000);
   endtask

   task automatic t_reset();
      chk("R1 irq", {31'd0, irq}, 32'd0);
      chk("R1 word", evt_word, 32'd0);
   endtask

   task automatic t_edge_rise();
      wr(2'd0, 32'd1); wr(2'd1, 32'h0020); wr(2'd2, 32'h0);
      irq_en = 1'b1; tick(4);
      din[9] = 1'b1;
      tick(2); chk("R3 latency", {31'd0, irq}, 32'd0);
      tick(1); chk("R3 irq", {31'd0, irq}, 32'd1);
      chk("R3 word", evt_word, 32'h8000_0200);
      wr(2'd3, 32'h8000_0000);
      chk("R10 irq drops", {31'd0, irq}, 32'd0);
      din[9] = 1'b0; tick(4);
      chk("R5 opposite edge", {31'd0, irq}, 32'd0);
   endtask

   task automatic t_edge_fall();
      wr(2'd1, 32'h0); wr(2'd2, 32'h0001);
      din[4] = 1'b1; tick(4);
      chk("R4 rise ignored", {31'd0, irq}, 32'd0);
      din[4] = 1'b0; tick(3);
      chk("R4 fall fires", evt_word, 32'h8000_0000);
      clear_all();
      din[11] = 1'b1; tick(4);
      chk("R5 unselected", {31'd0, irq}, 32'd0);
      din[11] = 1'b0; tick(4);
   endtask

   task automatic t_outside();
      wr(2'd1, 32'hFFFF); wr(2'd2, 32'hFFFF); tick(4);
      din[3:0] = 4'hF; din[31:20] = 12'hFFF; tick(5);
      chk("R2 outside window", {31'd0, irq}, 32'd0);
      din[3:0] = 4'h0; din[31:20] = 12'h0; tick(5);
      wr(2'd0, 32'd3);
      din[19:4] = 16'hFFFF; tick(5);
      chk("R5 mode 3 off", {31'd0, irq}, 32'd0);
      wr(2'd0, 32'd0);
      din[19:4] = 16'h0; tick(5);
      chk("R5 mode 0 off", {31'd0, irq}, 32'd0);
      wr(2'd0, 32'd1); irq_en = 1'b0; tick(2);
      din[10] = 1'b1; tick(5);
      chk("R8 disabled", {31'd0, irq}, 32'd0);
      din[10] = 1'b0; tick(5);
      irq_en = 1'b1; tick(2);
   endtask

   task automatic t_level();
      wr(2'd0, 32'd2); wr(2'd1, 32'h0003); wr(2'd2, 32'h0004); tick(4);
      din[4] = 1'b1; tick(5);
      chk("R6 partial", {31'd0, irq}, 32'd0);
      din[5] = 1'b1;
      tick(2); chk("R6 latency", {31'd0, irq}, 32'd0);
      tick(1); chk("R6 word", evt_word, 32'h8000_0030);
      clear_all(); tick(5);
      chk("R7 held locked", {31'd0, irq}, 32'd0);
      din[7] = 1'b1; tick(5);
      chk("R7 unselected keeps lock", {31'd0, irq}, 32'd0);
      din[5] = 1'b0; tick(4);
      chk("R7 break", {31'd0, irq}, 32'd0);
      din[5] = 1'b1; tick(3);
      chk("R7 rearmed", {31'd0, irq}, 32'd1);
      clear_all(); tick(3);
      wr(2'd1, 32'h0003);
      chk("R12 write cycle quiet", {31'd0, irq}, 32'd0);
      tick(1);
      chk("R12 lock released", {31'd0, irq}, 32'd1);
      clear_all();
      wr(2'd0, 32'd0); din = '0; tick(5);
   endtask

   task automatic t_flags();
      tmr_pulse = 1'b1; tick(1); tmr_pulse = 1'b0;
      chk("R9 timer bit", {27'd0, evt_word[31:27]}, 32'h08);
      cnt_pulse = 3'b010; tick(1); cnt_pulse = 3'b000;
      chk("R9 counter bit", {27'd0, evt_word[31:27]}, 32'h0A);
      cnt_pulse = 3'b101; tick(1); cnt_pulse = 3'b000;
      chk("R9 counters 2/0", {27'd0, evt_word[31:27]}, 32'h0F);
      chk("R9 reserved", evt_word & 32'h07F0_000F, 32'h0);
      wr(2'd3, 32'h4000_0000);
      chk("R10 partial clear", {27'd0, evt_word[31:27]}, 32'h07);
      chk("R10 irq stays", {31'd0, irq}, 32'd1);
      clear_all();
      chk("R10 all clear", {31'd0, irq}, 32'd0);
   endtask

   task automatic t_collide();
      tmr_pulse = 1'b1;
      wr(2'd3, 32'h4000_0000);
      tmr_pulse = 1'b0;
      chk("R11 timer wins", {31'd0, evt_word[30]}, 32'd1);
      clear_all();
      wr(2'd0, 32'd1); wr(2'd1, 32'h0100); wr(2'd2, 32'h0); tick(3);
      tmr_pulse = 1'b1; tick(1); tmr_pulse = 1'b0;
      din[12] = 1'b1; tick(2);
      wr(2'd3, 32'hC000_0000);
      chk("R11 cos wins", {30'd0, evt_word[31:30]}, 32'h2);
      chk("R11 snapshot", evt_word[19:0], 32'h0_1000);
      clear_all();
   endtask

   initial begin
      #(4 * 100000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=running expected=done");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      tick(1);
      t_reset();
      tick(2); rst_n = 1'b1; tick(2);
      t_reset();
      t_edge_rise();
      t_edge_fall();
      t_outside();
      t_level();
      t_flags();
      t_collide();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule